// File: doc/BRIEF.md
# Upper-Neighbour Tag Lookahead Controller

This block sits beside the line memory that holds upper-neighbour pixels for a block-based video decoder. For every 4x4 sub-block of the current row it derives a two-bit usage tag. One bit says whether intra prediction of the sub-block below will need these pixels. The other says whether the deblocking filter on the horizontal edge below will need them. The tag is stored per column in a one-row tag register file. The tag that the same column stored one row earlier is read back and compared with the new one. A mismatch is a prediction miss, and an external fetch unit uses it to refetch pixels from frame memory.

The controller also gates the pixel line memory. A sub-block whose tag is all-zero is not written. A kept sub-block is given the next free slot of a compacted line memory. That memory has ceil(NCOLS/CORR) slots instead of one slot per column, with CORR chosen at design time. Once the slots are used up, further kept sub-blocks in the row are dropped. A per-row miss counter gives the miss rate of the row.

Top module: `nt_lookahead_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `miss_o`, `miss_col_o`, `line_wen_o`, `line_slot_o` and `miss_cnt_o` are all zero.
- R2: Tag bit 0 (intra use) is 1 when `is_intra_i` is high and `intra_mode_i` is neither 1 (horizontal) nor 8 (horizontal-up); mode 0 (vertical) and every other code set it.
- R3: Tag bit 1 (deblocking use) is 1 when `dbk_en_i` is high and `bs_i` is non-zero; a zero strength (skip) clears it.
- R4: A block sampled with `blk_valid_i` at clock edge k produces its results after edge k+1. `miss_o` is high for that one cycle exactly when its tag differs from the neighbour tag, and `miss_col_o` then carries its column. Without a miss, `miss_col_o` is zero.
- R5: On a row opened with `slice_first_i` high, the neighbour tag is taken as zero for every column, whatever the register file holds.
- R6: Each block's tag is written into its column and becomes the neighbour tag for that column in the next row. The read of a column happens before the write of the same column.
- R7: `line_wen_o` is high with the block's result when its tag is non-zero and a slot is free. `line_slot_o` then gives the slot, numbered 0,1,2,... in order of kept blocks and restarting at 0 on each `row_start_i`.
- R8: With CORR=2 and NCOLS=12 (6 slots), the seventh and later kept blocks of a row get `line_wen_o` low.
- R9: `miss_cnt_o` counts the misses of the current row and is updated together with `miss_o`. It reads zero after the edge that samples `row_start_i`.
- R10: Blocks may arrive on consecutive cycles, one per cycle, and results leave in arrival order with the same one-edge latency.
- R11: One edge after a cycle without a valid block, `miss_o` and `line_wen_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_start_i | input | 1 | One-cycle strobe opening a new row of sub-blocks |
| slice_first_i | input | 1 | Sampled with `row_start_i`: the new row is the first row of a slice |
| blk_valid_i | input | 1 | A sub-block descriptor is present |
| blk_col_i | input | COL_W | Sub-block column index within the row |
| is_intra_i | input | 1 | Sub-block below is intra coded |
| intra_mode_i | input | 4 | 4x4 intra mode code |
| dbk_en_i | input | 1 | Deblocking enabled for the slice |
| bs_i | input | 3 | Boundary strength of the horizontal edge below |
| miss_o | output | 1 | Tag mismatch pulse |
| miss_col_o | output | COL_W | Column of the missed sub-block |
| line_wen_o | output | 1 | Write enable for the pixel line memory |
| line_slot_o | output | SLOT_W | Slot in the compacted line memory |
| miss_cnt_o | output | CNT_W | Misses in the current row |

## Verification
Two cases are hard to reach from the ports. In the first, the slot pool runs out inside a row. In the second, a slice-start row meets a register file full of non-zero tags from the previous row. The stimulus handles the first with a row pattern where eight of twelve sub-blocks need keeping, so the last two kept blocks find no slot. It handles the second by replaying that same pattern on a row flagged as a slice start: every stored tag would match, yet each non-zero tag must still report a miss. A back-to-back row sends one block per cycle, so the register-file read of one column shares an edge with the write of the previous column.

// File: rtl/nt_pkg.sv
// Package: shared tag type and intra mode codes for the neighbour-tag controller.
// Assumes 4-bit intra mode codes as delivered by the syntax parser.
package nt_pkg;

    // Usage tag of one sub-block: one bit per consumer of the upper pixels.
    typedef struct packed {
        logic dbk;    // deblocking filter of the edge below needs the pixels
        logic intra;  // intra prediction of the block below needs the pixels
    } nt_tag_t;

    localparam logic [3:0] IMODE_HORZ    = 4'd1;
    localparam logic [3:0] IMODE_HORZ_UP = 4'd8;

endpackage

// File: rtl/nt_tag_derive.sv
// Module: nt_tag_derive
// Derives the two-bit usage tag of one sub-block from its decoded header fields.
// Assumes: horizontal-family intra modes do not read the row above, and a zero
// boundary strength means the edge is skipped by the filter.
module nt_tag_derive
    import nt_pkg::*;
(
    input  logic       is_intra_i,
    input  logic [3:0] intra_mode_i,
    input  logic       dbk_en_i,
    input  logic [2:0] bs_i,
    output nt_tag_t    tag_o
);

    // Combine mode and filter decisions into the tag.
    always_comb begin
        tag_o.intra = is_intra_i
                    && (intra_mode_i != IMODE_HORZ)
                    && (intra_mode_i != IMODE_HORZ_UP);
        tag_o.dbk   = dbk_en_i && (bs_i != 3'd0);
    end

endmodule

// File: rtl/nt_tag_rf.sv
// Module: nt_tag_rf
// One-row tag register file with one registered read port and one write port.
// Assumes: a read and a write to the same entry on one edge return the old value,
// which gives the read-before-write ordering per column.
module nt_tag_rf
    import nt_pkg::*;
#(
    parameter int DEPTH = 12,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en_i,
    input  logic [AW-1:0] rd_addr_i,
    output nt_tag_t       rd_data_o,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  nt_tag_t       wr_data_i
);

    localparam logic [AW-1:0] DEPTH_C = AW'(DEPTH - 1);

    nt_tag_t mem [DEPTH];
    nt_tag_t rd_mux;

    // One storage entry per column, cleared on reset.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[gi] <= '0;
            else if (wr_en_i && (wr_addr_i == AW'(gi)))
                mem[gi] <= wr_data_i;
        end
    end

    // Select the addressed entry for the read port.
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < DEPTH; i++)
            if (rd_addr_i == AW'(i))
                rd_mux = mem[i];
    end

    // Register the read data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data_o <= '0;
        else if (rd_en_i)
            rd_data_o <= rd_mux;
    end

    // R6: writes stay inside the row.
    a_r6_wr_in_row: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> (wr_addr_i <= DEPTH_C));

    // R6: reads stay inside the row.
    a_r6_rd_in_row: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |-> (rd_addr_i <= DEPTH_C));

endmodule

// File: rtl/nt_slot_alloc.sv
// Module: nt_slot_alloc
// Hands out slots of the compacted pixel line memory in order, one per kept block.
// Assumes: clear_i opens a new row; a request in the same cycle still belongs to
// the old row and is answered from the old count.
module nt_slot_alloc #(
    parameter int SLOTS  = 6,
    parameter int SLOT_W = 3,
    parameter int CNTW   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              req_i,
    output logic              wen_o,
    output logic [SLOT_W-1:0] slot_o
);

    localparam logic [CNTW-1:0] SLOTS_C = CNTW'(SLOTS);

    logic [CNTW-1:0] used_q;
    logic            grant;

    // A slot is granted while the pool is not exhausted.
    always_comb grant = req_i && (used_q < SLOTS_C);

    // Track how many slots this row has consumed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            used_q <= '0;
        else if (clear_i)
            used_q <= '0;
        else if (grant)
            used_q <= used_q + 1'b1;
    end

    // Drive the line-memory write strobe and slot index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen_o  <= 1'b0;
            slot_o <= '0;
        end else begin
            wen_o  <= grant;
            slot_o <= grant ? used_q[SLOT_W-1:0] : '0;
        end
    end

    // R8: a written slot is always inside the pool.
    a_r8_slot_in_pool: assert property (@(posedge clk) disable iff (!rst_n)
        wen_o |-> (CNTW'(slot_o) < SLOTS_C));

    // R7: consecutive grants in one row take consecutive slots.
    a_r7_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && wen_o && $past(wen_o) && !$past(clear_i, 2))
        |-> (slot_o == $past(slot_o) + 1'b1));

endmodule

// File: rtl/nt_lookahead_ctrl.sv
// Module: nt_lookahead_ctrl (top)
// Two-stage controller. Stage 1 derives the tag of an incoming sub-block and
// reads the tag stored for its column one row earlier. Stage 2 compares the two,
// writes the new tag back, reports a miss and asks for a line-memory slot.
// Assumes: each column appears at most once per row; row_start_i may share a
// cycle with the first block of the new row.
module nt_lookahead_ctrl
    import nt_pkg::*;
#(
    parameter int NCOLS  = 12,
    parameter int CORR   = 2,
    parameter int COL_W  = (NCOLS > 1) ? $clog2(NCOLS) : 1,
    parameter int SLOTS  = (NCOLS + CORR - 1) / CORR,
    parameter int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    parameter int CNT_W  = $clog2(NCOLS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_start_i,
    input  logic              slice_first_i,
    input  logic              blk_valid_i,
    input  logic [COL_W-1:0]  blk_col_i,
    input  logic              is_intra_i,
    input  logic [3:0]        intra_mode_i,
    input  logic              dbk_en_i,
    input  logic [2:0]        bs_i,
    output logic              miss_o,
    output logic [COL_W-1:0]  miss_col_o,
    output logic              line_wen_o,
    output logic [SLOT_W-1:0] line_slot_o,
    output logic [CNT_W-1:0]  miss_cnt_o
);

    localparam int          USED_W = $clog2(SLOTS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NCOLS);

    nt_tag_t          new_tag;
    nt_tag_t          s1_tag_q;
    nt_tag_t          nbr_raw;
    nt_tag_t          nbr_tag;
    logic             s1_valid_q;
    logic [COL_W-1:0] s1_col_q;
    logic             s1_first_q;
    logic             row_first_q;
    logic             miss_d;
    logic             keep_d;

    // Stage 1: tag derivation for the incoming block.
    nt_tag_derive u_derive (
        .is_intra_i   (is_intra_i),
        .intra_mode_i (intra_mode_i),
        .dbk_en_i     (dbk_en_i),
        .bs_i         (bs_i),
        .tag_o        (new_tag)
    );

    // Register file: read in stage 1, write in stage 2.
    nt_tag_rf #(
        .DEPTH (NCOLS),
        .AW    (COL_W)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (blk_valid_i),
        .rd_addr_i (blk_col_i),
        .rd_data_o (nbr_raw),
        .wr_en_i   (s1_valid_q),
        .wr_addr_i (s1_col_q),
        .wr_data_i (s1_tag_q)
    );

    // Remember whether the open row starts a slice.
    always_ff @(posedge clk) begin
        if (!rst_n)
            row_first_q <= 1'b0;
        else if (row_start_i)
            row_first_q <= slice_first_i;
    end

    // Stage 1 pipeline register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid_q <= 1'b0;
            s1_col_q   <= '0;
            s1_tag_q   <= '0;
            s1_first_q <= 1'b0;
        end else begin
            s1_valid_q <= blk_valid_i;
            if (blk_valid_i) begin
                s1_col_q   <= blk_col_i;
                s1_tag_q   <= new_tag;
                s1_first_q <= row_start_i ? slice_first_i : row_first_q;
            end
        end
    end

    // Stage 2: neighbour selection, compare and keep decision.
    always_comb begin
        nbr_tag = s1_first_q ? '0 : nbr_raw;
        miss_d  = s1_valid_q && (s1_tag_q != nbr_tag);
        keep_d  = s1_valid_q && (s1_tag_q != '0);
    end

    // Stage 2 miss outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_o     <= 1'b0;
            miss_col_o <= '0;
        end else begin
            miss_o     <= miss_d;
            miss_col_o <= miss_d ? s1_col_q : '0;
        end
    end

    // Per-row miss counter, cleared by the row strobe, saturating at row length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            miss_cnt_o <= '0;
        else if (row_start_i)
            miss_cnt_o <= '0;
        else if (miss_d && (miss_cnt_o != CNT_MAX))
            miss_cnt_o <= miss_cnt_o + 1'b1;
    end

    // Slot allocation for kept blocks.
    nt_slot_alloc #(
        .SLOTS  (SLOTS),
        .SLOT_W (SLOT_W),
        .CNTW   (USED_W)
    ) u_alloc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (row_start_i),
        .req_i   (keep_d),
        .wen_o   (line_wen_o),
        .slot_o  (line_slot_o)
    );

    // R11: a cycle without a valid block yields no miss and no write one edge later.
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && !$past(blk_valid_i, 2))
        |-> (!miss_o && !line_wen_o));

    // R9: every miss outside a row strobe advances the counter by one.
    a_r9_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && miss_o && !$past(row_start_i) && ($past(miss_cnt_o) != CNT_MAX))
        |-> (miss_cnt_o == $past(miss_cnt_o) + 1'b1));

    // R9: the counter never exceeds the row length.
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        miss_cnt_o <= CNT_MAX);

    // R4: without a miss the reported column is zero.
    a_r4_col_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_o |-> (miss_col_o == '0));

endmodule

// File: tb/nt_lookahead_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: directed scenarios, each task checks its own results against a
// behavioural model written from the requirements.
module nt_lookahead_ctrl_tb_top;

    localparam int NCOLS = 12;
    localparam int CORR  = 2;
    localparam int SLOTS = (NCOLS + CORR - 1) / CORR;
    localparam int COL_W = $clog2(NCOLS);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int CNT_W = $clog2(NCOLS + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              row_start_i = 1'b0;
    logic              slice_first_i = 1'b0;
    logic              blk_valid_i = 1'b0;
    logic [COL_W-1:0]  blk_col_i = '0;
    logic              is_intra_i = 1'b0;
    logic [3:0]        intra_mode_i = '0;
    logic              dbk_en_i = 1'b0;
    logic [2:0]        bs_i = '0;
    logic              miss_o;
    logic [COL_W-1:0]  miss_col_o;
    logic              line_wen_o;
    logic [SLOT_W-1:0] line_slot_o;
    logic [CNT_W-1:0]  miss_cnt_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    // Model state.
    int m_tag [NCOLS];
    bit m_first;
    int m_cnt;
    int m_slot;

    // Expected results for the streaming scenario.
    int e_miss [NCOLS];
    int e_col  [NCOLS];
    int e_wen  [NCOLS];
    int e_slot [NCOLS];
    int e_cnt  [NCOLS];

    // Row patterns: intra flag, mode, filter enable, strength.
    int p_intra [NCOLS] = '{1, 1, 1, 0, 1, 0, 1, 1, 1, 0, 1, 1};
    int p_mode  [NCOLS] = '{0, 1, 8, 0, 2, 5, 1, 0, 4, 0, 3, 7};
    int p_dbk   [NCOLS] = '{0, 0, 1, 1, 1, 1, 1, 1, 0, 0, 1, 0};
    int p_bs    [NCOLS] = '{0, 0, 2, 0, 4, 1, 0, 3, 2, 0, 1, 0};

    always #2.5 clk = ~clk;

    nt_lookahead_ctrl #(.NCOLS(NCOLS), .CORR(CORR)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .row_start_i   (row_start_i),
        .slice_first_i (slice_first_i),
        .blk_valid_i   (blk_valid_i),
        .blk_col_i     (blk_col_i),
        .is_intra_i    (is_intra_i),
        .intra_mode_i  (intra_mode_i),
        .dbk_en_i      (dbk_en_i),
        .bs_i          (bs_i),
        .miss_o        (miss_o),
        .miss_col_o    (miss_col_o),
        .line_wen_o    (line_wen_o),
        .line_slot_o   (line_slot_o),
        .miss_cnt_o    (miss_cnt_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Tag from the rules of R2 and R3.
    function automatic int ref_tag(input int intra, input int mode, input int dbk, input int bs);
        int b0, b1;
        b0 = (intra != 0 && mode != 1 && mode != 8) ? 1 : 0;
        b1 = (dbk != 0 && bs != 0) ? 1 : 0;
        return b1 * 2 + b0;
    endfunction

    // Advance the model by one block and return its expected results.
    task automatic model_step(input int col, input int tag,
                              output int miss, output int wen, output int slot, output int cnt);
        int nb;
        nb = m_first ? 0 : m_tag[col];
        miss = (tag != nb) ? 1 : 0;
        m_tag[col] = tag;
        if (miss != 0 && m_cnt < NCOLS) m_cnt++;
        wen = (tag != 0 && m_slot < SLOTS) ? 1 : 0;
        slot = (wen != 0) ? m_slot : 0;
        if (wen != 0) m_slot++;
        cnt = m_cnt;
    endtask

    task automatic drive_blk(input int col, input int intra, input int mode, input int dbk, input int bs);
        blk_valid_i  = 1'b1;
        blk_col_i    = COL_W'(col);
        is_intra_i   = (intra != 0);
        intra_mode_i = 4'(mode);
        dbk_en_i     = (dbk != 0);
        bs_i         = 3'(bs);
    endtask

    // Open a row; check the counter clear (R9).
    task automatic row_begin(input bit first);
        @(negedge clk);
        row_start_i   = 1'b1;
        slice_first_i = first;
        @(negedge clk);
        row_start_i   = 1'b0;
        slice_first_i = 1'b0;
        m_first = first;
        m_cnt = 0;
        m_slot = 0;
        chk("R9 counter clear on row start", int'(miss_cnt_o), 0);
    endtask

    // Send one isolated block and check its pulse and the idle cycle after it.
    task automatic send_one(input int col, input int intra, input int mode, input int dbk, input int bs,
                            input string req);
        int tag, miss, wen, slot, cnt;
        tag = ref_tag(intra, mode, dbk, bs);
        model_step(col, tag, miss, wen, slot, cnt);
        @(negedge clk);
        drive_blk(col, intra, mode, dbk, bs);
        @(negedge clk);
        blk_valid_i = 1'b0;
        @(negedge clk);
        chk({req, " R4 miss"}, int'(miss_o), miss);
        chk({req, " R4 miss column"}, int'(miss_col_o), (miss != 0) ? col : 0);
        chk({req, " R7 write enable"}, int'(line_wen_o), wen);
        chk({req, " R7 slot"}, int'(line_slot_o), slot);
        chk({req, " R9 miss count"}, int'(miss_cnt_o), cnt);
        @(negedge clk);
        chk({req, " R11 miss after idle"}, int'(miss_o), 0);
        chk({req, " R11 write after idle"}, int'(line_wen_o), 0);
    endtask

    // R1: reset values.
    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 miss", int'(miss_o), 0);
        chk("R1 miss column", int'(miss_col_o), 0);
        chk("R1 write enable", int'(line_wen_o), 0);
        chk("R1 slot", int'(line_slot_o), 0);
        chk("R1 miss count", int'(miss_cnt_o), 0);
        rst_n = 1'b1;
        for (int i = 0; i < NCOLS; i++) m_tag[i] = 0;
    endtask

    // R2, R3, R5, R7, R8: slice-start row with more kept blocks than slots.
    task automatic test_first_row();
        row_begin(1'b1);
        for (int c = 0; c < NCOLS; c++)
            send_one(c, p_intra[c], p_mode[c], p_dbk[c], p_bs[c], "R5 R2 R3 R8 first row");
    endtask

    // R4, R6: second row mixing repeated and changed tags.
    task automatic test_compare_row();
        row_begin(1'b0);
        for (int c = 0; c < NCOLS; c++) begin
            int k;
            k = (c % 2 == 0) ? c : (c + 3) % NCOLS;
            send_one(c, p_intra[k], p_mode[k], p_dbk[k], p_bs[k], "R6 R4 compare row");
        end
    endtask

    // R5: slice start again; stored tags must be ignored.
    task automatic test_slice_restart();
        row_begin(1'b0);
        for (int c = 0; c < NCOLS; c++)
            send_one(c, p_intra[c], p_mode[c], p_dbk[c], p_bs[c], "R6 reload row");
        row_begin(1'b1);
        for (int c = 0; c < NCOLS; c++)
            send_one(c, p_intra[c], p_mode[c], p_dbk[c], p_bs[c], "R5 slice restart");
    endtask

    // R10: one block per cycle through a whole row.
    task automatic test_stream(input int mul);
        row_begin(1'b0);
        for (int j = 0; j < NCOLS; j++) begin
            int k, tag, miss, wen, slot, cnt;
            k = (j * mul + 1) % NCOLS;
            tag = ref_tag(p_intra[k], p_mode[k], p_dbk[k], p_bs[k]);
            model_step(j, tag, miss, wen, slot, cnt);
            e_miss[j] = miss; e_col[j] = (miss != 0) ? j : 0;
            e_wen[j] = wen; e_slot[j] = slot; e_cnt[j] = cnt;
        end
        for (int j = 0; j < NCOLS + 2; j++) begin
            @(negedge clk);
            if (j >= 2) begin
                chk("R10 stream miss", int'(miss_o), e_miss[j-2]);
                chk("R10 stream miss column", int'(miss_col_o), e_col[j-2]);
                chk("R10 stream write enable", int'(line_wen_o), e_wen[j-2]);
                chk("R10 stream slot", int'(line_slot_o), e_slot[j-2]);
                chk("R10 stream miss count", int'(miss_cnt_o), e_cnt[j-2]);
            end
            if (j < NCOLS) begin
                int k;
                k = (j * mul + 1) % NCOLS;
                drive_blk(j, p_intra[k], p_mode[k], p_dbk[k], p_bs[k]);
            end else begin
                blk_valid_i = 1'b0;
            end
        end
        @(negedge clk);
        chk("R11 stream drained miss", int'(miss_o), 0);
        chk("R11 stream drained write", int'(line_wen_o), 0);
    endtask

    initial begin
        test_reset();
        test_first_row();
        test_compare_row();
        test_slice_restart();
        test_stream(5);
        test_stream(7);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule